// File: doc/BRIEF.md
# I2C Serial-Clock Rate Generator

This block produces the serial-clock timing for an I2C master from the system clock. Division happens in two stages. A power-of-two predivider, picked by a 2-bit field, comes first. A half-period counter follows. Its length is the 8-bit divider value plus a fixed offset of 3, plus 2 more when the input filter is on. Each of the two SCL phases lasts exactly that many predivided ticks, so one SCL period takes `(32 >> sel) * 2 * (div + 3 + 2*filter)` system clocks.

Software works out the settings and writes them to a 4-bit mode word and a byte-wide divider. The block returns the following:
- `scl_level`, the SCL level to drive.
- `scl_tick`, a one-cycle pulse on every SCL toggle.
- `qtr_strobe` with `qtr_idx`, which mark the four quarter points of each period for the bit engine.

Settings are captured only at the start of a period, so a phase is never cut short.

The controller is a three-state machine. `PH_IDLE` has the clock released high and the counters cleared. `PH_LOW` is the low phase and `PH_HIGH` is the high phase. It has these transitions:
- `PH_IDLE` to `PH_LOW` when enable is seen high.
- `PH_LOW` to `PH_HIGH` at the end of the low half.
- `PH_HIGH` to `PH_LOW` at the end of the high half, which is the period boundary.
- `PH_LOW` or `PH_HIGH` to `PH_IDLE` whenever enable is seen low.

Top module: `i2c_brg`

## Requirements
- R1: While reset is asserted, `scl_level` is 1 and `scl_tick`, `qtr_strobe` and `qtr_idx` are all 0.
- R2: When `rate_mode[0]` (enable) is sampled low, the next clock gives `scl_level` = 1 with no tick and no strobe, and this holds for as long as enable stays low. `qtr_idx` keeps its last value.
- R3: The predivide ratio is 32, 16, 8 or 4 system clocks per tick for `rate_mode[2:1]` = 0, 1, 2 or 3.
- R4: Each SCL half lasts H = `brg_div` + 3 + 2*`rate_mode[3]` predivided ticks, so `rate_mode[3]` adds 2 ticks per half.
- R5: On the first clock edge at which enable is sampled high from idle, the registered outputs show `scl_level` = 0, `scl_tick` = 1 and a strobe with index 0.
- R6: The low and high halves of one period each last H times the predivide ratio in system clocks, including `brg_div` = 255 with the filter on.
- R7: Quarter strobes carry the index in `qtr_idx`. Index 0 comes with the fall and index 2 with the rise. Index 1 and index 3 fire floor(H/2) predivided ticks into the low half and the high half respectively.
- R8: The ratio, divider and filter settings are captured only when a period starts. A change made mid-period first affects the next period.
- R9: `scl_tick` pulses for exactly one cycle in the cycle where `scl_level` changes. The only exception is the release to 1 caused by disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_mode | input | 4 | bit0 enable, bits 2:1 predivide select, bit3 filter |
| brg_div | input | 8 | Half-period divider value |
| scl_tick | output | 1 | One-cycle pulse on each SCL toggle |
| scl_level | output | 1 | Generated SCL level |
| qtr_strobe | output | 1 | Quarter-point strobe |
| qtr_idx | output | 2 | Quarter index of the latest strobe |

## Verification
The assertions assume two things about the inputs. `rate_mode` and `brg_div` are synchronous to `clk`. Enable has a defined value from the first clock after reset, because the disable checks look one cycle back at it. The no-runt check depends on the shortest legal half, which is 3 ticks of the fastest predivider (12 clocks). That minimum holds only because the offset is built into the hardware and cannot be set below it. The stimulus changes inputs only on the falling clock edge, always drives enable, and changes settings both at period boundaries and part-way through a phase, so the capture rule is tested against a live counter.

// File: rtl/i2c_brg_pkg.sv
package i2c_brg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam logic [1:0] QTR_FALL = 2'd0;
    localparam logic [1:0] QTR_LMID = 2'd1;
    localparam logic [1:0] QTR_RISE = 2'd2;
    localparam logic [1:0] QTR_HMID = 2'd3;
endpackage

// File: rtl/brg_predivide.sv
module brg_predivide #(
    parameter int PRE_LOG2_MAX = 5,
    parameter int SEL_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = PRE_LOG2_MAX;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // terminal count = 2^(PRE_LOG2_MAX - sel) - 1
    always_comb begin
        last = CNT_W'((32'd1 << (PRE_LOG2_MAX - int'(sel))) - 32'd1);
        tick = run && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/brg_halfcount.sv
module brg_halfcount #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic [HALF_W-1:0] half_len,
    output logic              at_mid,
    output logic              at_end
);
    logic [HALF_W-1:0] cnt;

    always_comb begin
        at_end = adv && (cnt == half_len - HALF_W'(1));
        at_mid = adv && ((cnt + HALF_W'(1)) == (half_len >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_end ? '0 : cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/i2c_brg.sv
module i2c_brg
    import i2c_brg_pkg::*;
#(
    parameter int BRG_W        = 8,
    parameter int PRE_LOG2_MAX = 5,
    parameter int SEL_W        = 2,
    parameter int BASE_EXTRA   = 3,
    parameter int FILT_EXTRA   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       rate_mode,
    input  logic [BRG_W-1:0] brg_div,
    output logic             scl_tick,
    output logic             scl_level,
    output logic             qtr_strobe,
    output logic [1:0]       qtr_idx
);
    localparam int HALF_W = BRG_W + 1;

    phase_e            state, nxt;
    logic              en, filt;
    logic [SEL_W-1:0]  req_sel, cfg_sel;
    logic [HALF_W-1:0] req_half, cfg_half;
    logic              run, clear, load;
    logic              pre_tick, at_mid, at_end;
    logic              tick_n, mid_n;
    logic [1:0]        idx_n;

    always_comb begin
        en       = rate_mode[0];
        req_sel  = rate_mode[2:1];
        filt     = rate_mode[3];
        req_half = HALF_W'(brg_div) + HALF_W'(BASE_EXTRA)
                 + (filt ? HALF_W'(FILT_EXTRA) : HALF_W'(0));
        run      = (state != PH_IDLE);
        clear    = (state == PH_IDLE);
    end

    brg_predivide #(
        .PRE_LOG2_MAX (PRE_LOG2_MAX),
        .SEL_W        (SEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .run   (run),
        .sel   (cfg_sel),
        .tick  (pre_tick)
    );

    brg_halfcount #(
        .HALF_W (HALF_W)
    ) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .adv      (pre_tick),
        .half_len (cfg_half),
        .at_mid   (at_mid),
        .at_end   (at_end)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE: if (en) nxt = PH_LOW;
            PH_LOW: begin
                if (!en)        nxt = PH_IDLE;
                else if (at_end) nxt = PH_HIGH;
            end
            PH_HIGH: begin
                if (!en)        nxt = PH_IDLE;
                else if (at_end) nxt = PH_LOW;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    // settings are captured only when a period begins
    always_comb begin
        load = en && ((state == PH_IDLE) || ((state == PH_HIGH) && at_end));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            cfg_sel  <= '0;
            cfg_half <= HALF_W'(BASE_EXTRA);
        end else begin
            state <= nxt;
            if (load) begin
                cfg_sel  <= req_sel;
                cfg_half <= req_half;
            end
        end
    end

    // output decode
    always_comb begin
        tick_n = (nxt != state) && (nxt != PH_IDLE);
        mid_n  = run && en && at_mid;
        if (tick_n)
            idx_n = (nxt == PH_HIGH) ? QTR_RISE : QTR_FALL;
        else if (mid_n)
            idx_n = (state == PH_HIGH) ? QTR_HMID : QTR_LMID;
        else
            idx_n = qtr_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_tick   <= 1'b0;
            scl_level  <= 1'b1;
            qtr_strobe <= 1'b0;
            qtr_idx    <= QTR_FALL;
        end else begin
            scl_tick   <= tick_n;
            scl_level  <= (nxt != PH_LOW);
            qtr_strobe <= tick_n || mid_n;
            qtr_idx    <= idx_n;
        end
    end
endmodule

// File: rtl/i2c_brg_chk.sv
module i2c_brg_chk #(
    parameter int MIN_HALF = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_bit,
    input logic       scl_tick,
    input logic       scl_level,
    input logic       qtr_strobe,
    input logic [1:0] qtr_idx
);
    logic [15:0] gap;
    logic        armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= '0;
            armed <= 1'b0;
        end else if (!en_bit) begin
            gap   <= '0;
            armed <= 1'b0;
        end else if (scl_tick) begin
            gap   <= '0;
            armed <= 1'b1;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 16'd1;
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_bit) |-> (!scl_tick && !qtr_strobe && scl_level)); // R2

    AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |-> (scl_level != $past(scl_level))); // R9

    AST_FALL_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_level) && !scl_level) |-> scl_tick); // R9

    AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        qtr_strobe |-> (qtr_idx[1] == scl_level)); // R7

    AST_TICK_EVEN_QTR: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |-> (qtr_strobe && !qtr_idx[0])); // R7

    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !qtr_strobe |-> $stable(qtr_idx)); // R2

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_tick && armed) |-> (gap >= 16'(MIN_HALF - 1))); // R6
endmodule

bind i2c_brg i2c_brg_chk #(.MIN_HALF(12)) u_brg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_bit     (rate_mode[0]),
    .scl_tick   (scl_tick),
    .scl_level  (scl_level),
    .qtr_strobe (qtr_strobe),
    .qtr_idx    (qtr_idx)
);

// File: tb/i2c_brg_tb_top.sv
`timescale 1ns/1ps
module i2c_brg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rate_mode = 4'b0000;
    logic [7:0] brg_div = 8'd0;
    logic       scl_tick, scl_level, qtr_strobe;
    logic [1:0] qtr_idx;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    i2c_brg dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_mode  (rate_mode),
        .brg_div    (brg_div),
        .scl_tick   (scl_tick),
        .scl_level  (scl_level),
        .qtr_strobe (qtr_strobe),
        .qtr_idx    (qtr_idx)
    );

    // behavioural reference: one clock count per phase
    int m_st = 0;      // 0 idle, 1 low, 2 high
    int m_j  = 0;
    int m_len = 0;     // clocks per half
    int m_mid = 0;     // clocks to mid strobe
    int m_lvl = 1, m_tick = 0, m_str = 0, m_idx = 0;

    task automatic m_capture();
        int p, h;
        p = 32 >> rate_mode[2:1];
        h = int'(brg_div) + 3 + (rate_mode[3] ? 2 : 0);
        m_len = h * p;
        m_mid = (h / 2) * p;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_j = 0; m_lvl = 1; m_tick = 0; m_str = 0; m_idx = 0;
        end else begin
            m_tick = 0;
            m_str  = 0;
            if (m_st == 0) begin
                if (rate_mode[0]) begin
                    m_capture();
                    m_st = 1; m_j = 0; m_lvl = 0; m_tick = 1; m_str = 1; m_idx = 0;
                end
            end else if (!rate_mode[0]) begin
                m_st = 0; m_lvl = 1;
            end else begin
                m_j++;
                if (m_j == m_len) begin
                    m_j = 0; m_tick = 1; m_str = 1;
                    if (m_st == 1) begin
                        m_st = 2; m_lvl = 1; m_idx = 2;
                    end else begin
                        m_capture();
                        m_st = 1; m_lvl = 0; m_idx = 0;
                    end
                end else if (m_j == m_mid) begin
                    m_str = 1;
                    m_idx = (m_st == 1) ? 1 : 3;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "scl_level", int'(scl_level), m_lvl);
            chk("R9", "scl_tick", int'(scl_tick), m_tick);
            chk("R7", "qtr_strobe", int'(qtr_strobe), m_str);
            chk("R7", "qtr_idx", int'(qtr_idx), m_idx);
        end
    end

    task automatic apply(input bit en, input logic [1:0] sel, input bit f,
                         input logic [7:0] b, input int cycles, input string req);
        @(negedge clk);
        cur_req   = req;
        rate_mode = {f, sel, en};
        brg_div   = b;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "reset scl_level", int'(scl_level), 1);
        chk("R1", "reset scl_tick", int'(scl_tick), 0);
        chk("R1", "reset qtr_strobe", int'(qtr_strobe), 0);
        chk("R1", "reset qtr_idx", int'(qtr_idx), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        apply(1'b0, 2'd1, 1'b1, 8'd9, 40, "R2");      // R2 disabled, settings ignored
        apply(1'b1, 2'd3, 1'b0, 8'd0, 80, "R5");      // R5 start, shortest period
        apply(1'b1, 2'd0, 1'b0, 8'd0, 420, "R3");     // R3 ratio 32
        apply(1'b1, 2'd1, 1'b0, 8'd2, 400, "R3");     // R3 ratio 16
        apply(1'b1, 2'd2, 1'b0, 8'd1, 200, "R3");     // R3 ratio 8
        apply(1'b1, 2'd3, 1'b1, 8'd5, 300, "R4");     // R4 filter adds 2
        apply(1'b1, 2'd3, 1'b0, 8'd4, 200, "R4");     // R4 odd half length
        apply(1'b1, 2'd3, 1'b0, 8'd0, 31, "R8");      // R8 change mid-phase
        apply(1'b1, 2'd2, 1'b1, 8'd20, 900, "R8");
        apply(1'b0, 2'd2, 1'b1, 8'd20, 20, "R2");     // R2 disable mid-phase
        apply(1'b1, 2'd3, 1'b0, 8'd1, 100, "R5");     // R5 restart
        apply(1'b1, 2'd3, 1'b1, 8'd255, 4300, "R6");  // R6 largest divider
        apply(1'b0, 2'd3, 1'b1, 8'd255, 10, "R2");
        cmp_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule